// File: doc/BRIEF.md
# Dual-Plane Blinking Digit Store

This block holds the character codes for the digits of a dot-matrix LED display. Every digit owns two bytes, one in plane zero and one in plane one. A host write can put a byte into either plane or into both planes in the same cycle. The scan logic names a digit, and the block answers with a 7-bit index into a character font and a flag that asks the font path to invert the row data.

While blinking is off, the display always reads plane zero. While blinking is on, an internal phase bit picks the plane: plane zero during the first half of each blink period and plane one during the second. The phase advances on a prescaled `tick` input and toggles after a programmable number of ticks. Because of this, a character stored only in plane zero is lit in the first half of the period. A character stored only in plane one is lit in the second half. A character stored in both planes stays steady.

A global clear empties both planes in one cycle. A blink-restart input puts the phase back to the start of the first half.

Top module: `dual_plane_digit_store`

## Requirements
- R1: After synchronous reset, every stored byte is 0x00, `blink_phase` is 0, `rd_data` is 0x00, and `font_idx`/`font_inv` are 0 for every digit.
- R2: A write with `wr_plane` = 2'b01 stores `wr_data` into plane zero of digit `wr_digit` and leaves plane one alone.
- R3: A write with `wr_plane` = 2'b10 stores `wr_data` into plane one of digit `wr_digit` and leaves plane zero alone.
- R4: A write with `wr_plane` = 2'b11 stores `wr_data` into both planes of the digit in the same cycle.
- R5: A write with `wr_plane` = 2'b00 changes no stored byte.
- R6: When `blink_en` = 0, the scan output shows plane zero of `scan_digit`, whatever the phase is.
- R7: When `blink_en` = 1, the scan output shows plane zero while `blink_phase` = 0 and plane one while `blink_phase` = 1.
- R8: `font_idx` equals bits 6:0 of the selected byte, and `font_inv` equals bit 7 (1 = invert the font row).
- R9: When `clear_all` is high at a clock edge, all bytes of both planes read 0x00 after that edge, even if a write is presented in the same cycle.
- R10: The phase only changes on cycles where `tick` is high. A tick toggles `blink_phase` when the tick count since the last toggle or restart has reached `blink_rate`, so the phase toggles once every `blink_rate`+1 ticks.
- R11: `blink_rst` forces `blink_phase` to 0 and restarts the tick count at the next edge. It takes priority over a tick in the same cycle.
- R12: `rd_data` returns, combinationally, the plane-zero byte of digit `rd_digit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_all | input | 1 | Zero both planes of every digit |
| wr_en | input | 1 | Write strobe |
| wr_digit | input | DIG_W (2) | Digit addressed by the write |
| wr_plane | input | 2 | Plane mask: bit0 plane zero, bit1 plane one |
| wr_data | input | 8 | Byte to store: bit7 invert, bits 6:0 font index |
| rd_digit | input | DIG_W (2) | Digit read back through `rd_data` |
| rd_data | output | 8 | Plane-zero byte of `rd_digit` |
| blink_en | input | 1 | Global blink enable |
| blink_rst | input | 1 | Restart the blink phase at the first half |
| tick | input | 1 | Prescaled blink time base pulse |
| blink_rate | input | RATE_W (4) | Ticks per half period, minus one |
| scan_digit | input | DIG_W (2) | Digit being scanned |
| font_idx | output | 7 | Font character index for the scanned digit |
| font_inv | output | 1 | Invert font row data for the scanned digit |
| blink_phase | output | 1 | 0 = first half, 1 = second half |

## Verification
A corrupted byte in either plane shows up on the scan port in the cycle right after the faulty write. That byte reaches the port only during the half period in which its plane is selected, so the bench scans every digit in both phases and with blink both on and off. A wrong phase count shows on `blink_phase` at the first tick where the toggle lands one tick early or late. Random mixes of writes, clears and restarts are compared against a byte-level model after every edge, which catches a stale byte or a wrongly ordered priority in the next cycle.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = 7;
    localparam int unsigned N_PLANES = 2;

    // stored byte: top bit asks for inverted font rows, rest indexes the font
    typedef struct packed {
        logic             inv;
        logic [IDX_W-1:0] idx;
    } glyph_t;

    // write plane mask encoding
    typedef enum logic [1:0] {
        PL_NONE = 2'b00,
        PL_ZERO = 2'b01,
        PL_ONE  = 2'b10,
        PL_BOTH = 2'b11
    } plane_sel_t;

    function automatic logic plane_hit(plane_sel_t sel, int unsigned plane);
        return sel[plane];
    endfunction

    function automatic glyph_t to_glyph(logic [BYTE_W-1:0] b);
        return glyph_t'(b);
    endfunction

endpackage

// File: rtl/dps_plane_bank.sv
module dps_plane_bank
    import dps_pkg::*;
#(
    parameter int N_DIG = 4,
    localparam int DIG_W = $clog2(N_DIG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              we,
    input  logic [DIG_W-1:0]  waddr,
    input  glyph_t            wdata,
    output glyph_t            q [N_DIG]
);

    for (genvar d = 0; d < N_DIG; d++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                q[d] <= '0;
            end else if (we && (waddr == DIG_W'(d))) begin
                q[d] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dps_blink_timer.sv
module dps_blink_timer #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              phase
);

    logic [RATE_W-1:0] tick_cnt;
    logic              wrap;

    assign wrap = (tick_cnt >= rate);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tick_cnt <= '0;
            phase    <= 1'b0;
        end else if (tick) begin
            if (wrap) begin
                tick_cnt <= '0;
                phase    <= ~phase;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dps_glyph_mux.sv
module dps_glyph_mux
    import dps_pkg::*;
#(
    parameter int N_DIG = 4,
    localparam int DIG_W = $clog2(N_DIG)
) (
    input  glyph_t            plane0 [N_DIG],
    input  glyph_t            plane1 [N_DIG],
    input  logic [DIG_W-1:0]  sel_digit,
    input  logic              blink_en,
    input  logic              phase,
    output glyph_t            glyph
);

    logic use_p1;
    assign use_p1 = blink_en && phase;

    always_comb begin
        glyph = use_p1 ? plane1[sel_digit] : plane0[sel_digit];
    end

endmodule

// File: rtl/dual_plane_digit_store.sv
module dual_plane_digit_store
    import dps_pkg::*;
#(
    parameter int N_DIG  = 4,
    parameter int RATE_W = 4,
    localparam int DIG_W = $clog2(N_DIG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic              wr_en,
    input  logic [DIG_W-1:0]  wr_digit,
    input  logic [1:0]        wr_plane,
    input  logic [7:0]        wr_data,
    input  logic [DIG_W-1:0]  rd_digit,
    output logic [7:0]        rd_data,
    input  logic              blink_en,
    input  logic              blink_rst,
    input  logic              tick,
    input  logic [RATE_W-1:0] blink_rate,
    input  logic [DIG_W-1:0]  scan_digit,
    output logic [6:0]        font_idx,
    output logic              font_inv,
    output logic              blink_phase
);

    plane_sel_t plane_mask;
    glyph_t     wr_glyph;
    glyph_t     bank_q [N_PLANES][N_DIG];
    glyph_t     scan_glyph;
    logic       phase;

    assign plane_mask = plane_sel_t'(wr_plane);
    assign wr_glyph   = to_glyph(wr_data);

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        logic plane_we;
        assign plane_we = wr_en && plane_hit(plane_mask, p);

        dps_plane_bank #(.N_DIG(N_DIG)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .clear (clear_all),
            .we    (plane_we),
            .waddr (wr_digit),
            .wdata (wr_glyph),
            .q     (bank_q[p])
        );
    end

    dps_blink_timer #(.RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (blink_rst),
        .tick    (tick),
        .rate    (blink_rate),
        .phase   (phase)
    );

    dps_glyph_mux #(.N_DIG(N_DIG)) u_mux (
        .plane0    (bank_q[0]),
        .plane1    (bank_q[1]),
        .sel_digit (scan_digit),
        .blink_en  (blink_en),
        .phase     (phase),
        .glyph     (scan_glyph)
    );

    assign rd_data     = bank_q[0][rd_digit];
    assign font_idx    = scan_glyph.idx;
    assign font_inv    = scan_glyph.inv;
    assign blink_phase = phase;

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int N_DIG = 4,
    localparam int DIG_W = $clog2(N_DIG)
) (
    input logic             clk,
    input logic             rst,
    input logic             clear_all,
    input logic             wr_en,
    input logic [DIG_W-1:0] wr_digit,
    input logic [1:0]       wr_plane,
    input logic [7:0]       wr_data,
    input logic [DIG_W-1:0] rd_digit,
    input logic [7:0]       rd_data,
    input logic             blink_en,
    input logic             blink_rst,
    input logic             tick,
    input logic [DIG_W-1:0] scan_digit,
    input logic [6:0]       font_idx,
    input logic             font_inv,
    input logic             blink_phase
);

    // R9: clear empties every byte by the next edge
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (rd_data == 8'h00 && font_idx == 7'h00 && !font_inv));

    // R11: restart forces first half
    p_restart_phase_r11: assert property (@(posedge clk) disable iff (rst)
        blink_rst |=> !blink_phase);

    // R10: no tick and no restart keeps the phase
    p_phase_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !blink_rst) |=> $stable(blink_phase));

    // R2: plane-zero write is visible on the read port
    p_p0_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_plane[0] && !clear_all && wr_digit == rd_digit)
        |=> (rd_digit != $past(rd_digit) || rd_data == $past(wr_data)));

    // R3 / R5: plane zero unchanged without a plane-zero write or clear
    p_p0_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clear_all && !(wr_en && wr_plane[0]))
        |=> (rd_digit != $past(rd_digit) || $stable(rd_data)));

    // R6 / R7 / R8: plane zero drives scan when blink off or in first half
    p_p0_view_r6: assert property (@(posedge clk) disable iff (rst)
        (scan_digit == rd_digit && (!blink_en || !blink_phase))
        |-> ({font_inv, font_idx} == rd_data));

endmodule

bind dual_plane_digit_store dps_checker #(.N_DIG(N_DIG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear_all   (clear_all),
    .wr_en       (wr_en),
    .wr_digit    (wr_digit),
    .wr_plane    (wr_plane),
    .wr_data     (wr_data),
    .rd_digit    (rd_digit),
    .rd_data     (rd_data),
    .blink_en    (blink_en),
    .blink_rst   (blink_rst),
    .tick        (tick),
    .scan_digit  (scan_digit),
    .font_idx    (font_idx),
    .font_inv    (font_inv),
    .blink_phase (blink_phase)
);

// File: tb/dual_plane_digit_store_test.sv
`timescale 1ns/1ps
module dual_plane_digit_store_test;

    localparam int N_DIG  = 4;
    localparam int RATE_W = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear_all = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_digit = '0;
    logic [1:0] wr_plane = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_digit = '0;
    logic [7:0] rd_data;
    logic       blink_en = 1'b0;
    logic       blink_rst = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] blink_rate = '0;
    logic [1:0] scan_digit = '0;
    logic [6:0] font_idx;
    logic       font_inv;
    logic       blink_phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // byte-level model
    logic [7:0] m0 [N_DIG];
    logic [7:0] m1 [N_DIG];
    logic       mph;
    int         mcnt;

    always #2 clk = ~clk;

    dual_plane_digit_store #(.N_DIG(N_DIG), .RATE_W(RATE_W)) uut (
        .clk(clk), .rst(rst), .clear_all(clear_all), .wr_en(wr_en),
        .wr_digit(wr_digit), .wr_plane(wr_plane), .wr_data(wr_data),
        .rd_digit(rd_digit), .rd_data(rd_data), .blink_en(blink_en),
        .blink_rst(blink_rst), .tick(tick), .blink_rate(blink_rate),
        .scan_digit(scan_digit), .font_idx(font_idx), .font_inv(font_inv),
        .blink_phase(blink_phase)
    );

    function automatic logic [7:0] exp_sel(int d);
        return (blink_en && mph) ? m1[d] : m0[d];
    endfunction

    task automatic model_edge();
        if (rst || clear_all) begin
            for (int d = 0; d < N_DIG; d++) begin m0[d] = '0; m1[d] = '0; end
        end else if (wr_en) begin
            if (wr_plane[0]) m0[wr_digit] = wr_data;
            if (wr_plane[1]) m1[wr_digit] = wr_data;
        end
        if (rst || blink_rst) begin
            mph = 1'b0; mcnt = 0;
        end else if (tick) begin
            if (mcnt >= int'(blink_rate)) begin mcnt = 0; mph = ~mph; end
            else mcnt++;
        end
    endtask

    task automatic step(bit w, int d, bit [1:0] pl, bit [7:0] dat,
                        bit clr, bit brst, bit tk);
        wr_en = w; wr_digit = 2'(d); wr_plane = pl; wr_data = dat;
        clear_all = clr; blink_rst = brst; tick = tk;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 1'b0; clear_all = 1'b0; blink_rst = 1'b0; tick = 1'b0;
    endtask

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check_val(req, "blink_phase", int'(blink_phase), int'(mph));
        for (int d = 0; d < N_DIG; d++) begin
            scan_digit = 2'(d); rd_digit = 2'(d);
            #0.2;
            check_val(req, "rd_data", int'(rd_data), int'(m0[d]));
            check_val(req, "font_idx", int'(font_idx), int'(exp_sel(d) & 8'h7f));
            check_val(req, "font_inv", int'(font_inv), int'(exp_sel(d) >> 7));
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int d = 0; d < N_DIG; d++) begin m0[d] = '0; m1[d] = '0; end
        mph = 1'b0; mcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.1;
        check_all("R1");

        // R2: plane zero only
        step(1, 2, 2'b01, 8'h85, 0, 0, 0);
        check_all("R2");
        // R3: plane one only, plane zero keeps 0x85
        step(1, 2, 2'b10, 8'h3C, 0, 0, 0);
        check_all("R3");
        // R7: blink on, first half shows plane zero
        blink_en = 1'b1; blink_rate = 4'd0;
        check_all("R7");
        // R8: 0x85 -> index 5, invert set
        scan_digit = 2'd2; #0.2;
        check_val("R8", "font_idx", int'(font_idx), 5);
        check_val("R8", "font_inv", int'(font_inv), 1);
        // one tick at rate 0 -> second half shows plane one
        step(0, 0, 2'b00, 8'h00, 0, 0, 1);
        check_val("R7", "blink_phase", int'(blink_phase), 1);
        check_all("R7");
        // R6: blink off shows plane zero even in second half
        blink_en = 1'b0;
        check_all("R6");
        // R4: both planes
        step(1, 1, 2'b11, 8'h4F, 0, 0, 0);
        blink_en = 1'b1;
        check_all("R4");
        // R5: empty mask writes nothing
        step(1, 1, 2'b00, 8'h11, 0, 0, 0);
        check_all("R5");
        // R12: read port returns plane zero
        rd_digit = 2'd2; #0.2;
        check_val("R12", "rd_data", int'(rd_data), 8'h85);
        // R9: clear beats a same-cycle write
        step(1, 3, 2'b11, 8'hAA, 1, 0, 0);
        check_all("R9");
        // R10: rate 2 -> toggle on third tick
        step(0, 0, 2'b00, 8'h00, 0, 1, 0);
        blink_rate = 4'd2;
        step(0, 0, 2'b00, 8'h00, 0, 0, 1);
        step(0, 0, 2'b00, 8'h00, 0, 0, 0);
        step(0, 0, 2'b00, 8'h00, 0, 0, 1);
        check_val("R10", "blink_phase", int'(blink_phase), 0);
        step(0, 0, 2'b00, 8'h00, 0, 0, 1);
        check_val("R10", "blink_phase", int'(blink_phase), 1);
        // R11: restart with tick -> first half, count restarts
        step(0, 0, 2'b00, 8'h00, 0, 1, 1);
        check_val("R11", "blink_phase", int'(blink_phase), 0);
        step(0, 0, 2'b00, 8'h00, 0, 0, 1);
        check_val("R11", "blink_phase", int'(blink_phase), 0);
        check_all("R11");

        // constrained random mix checked against the model
        for (int i = 0; i < 1500; i++) begin
            bit brst;
            brst = ($urandom_range(0, 31) == 0);
            if (brst) blink_rate = 4'($urandom_range(0, 3));
            blink_en = 1'($urandom_range(0, 1));
            step(($urandom_range(0, 2) != 0), int'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), 8'($urandom),
                 ($urandom_range(0, 63) == 0), brst,
                 ($urandom_range(0, 1) == 1));
            check_all("R7");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule